// File: doc/BRIEF.md
# Single-Channel Countdown Timer with Register Interface

This block is a single countdown channel controlled through a simple 32-bit register port. A word is written when the write strobe is high on a clock edge, and the read data always reflects the currently addressed register. Software sets an interval and copies it into the counter through a self-clearing reload bit. It then chooses a tick source, a power-of-two prescaler and either periodic or one-shot operation, and sets the channel running.

The counter steps down once per prescaled tick. When it reaches zero it latches a pending flag. In periodic mode the next tick refills the counter from the interval. In one-shot mode the channel switches itself off. The interrupt line is the pending flag qualified by a separate global interrupt-enable register. The pending flag is cleared by writing a one to it.

Top module: `mm_timer`

## Requirements
- R1: After reset every register reads 0 (global enable, status, control, interval, count) and `irq_o` is low.
- R2: Offsets are 0x00 global enable (bit 0), 0x04 status (bit 0 pending), 0x10 control, 0x14 interval, 0x18 count. The interval reads back what was written. The control register reads back bit 0 run, bits 3:2 source, bits 6:4 prescale and bit 7 one-shot. Writes to 0x18 or to unmapped offsets change nothing, and unmapped offsets read 0.
- R3: A control write with bit 1 set copies the interval into the count on that write's clock edge. Bit 1 always reads 0, so the copy can be made while stopped, before the run bit is set.
- R4: While run (control bit 0) is 1, the count drops by one per prescaled tick. While run is 0, the count holds.
- R5: Prescale field value n gives one prescaled tick per 2^n ticks of the selected source. The divider is held at zero while stopped, so after the run bit is set the first prescaled tick comes on the 2^n-th source tick.
- R6: Source field value s makes only `src_tick_i[s]` pulses count. Index 1 is the main high-frequency oscillator tick.
- R7: A tick that takes the count from 1 to 0 sets the pending flag (status bit 0).
- R8: With control bit 7 at 0 (periodic), a tick that arrives while the count is 0 reloads the interval, so an interval of N repeats every N+1 ticks.
- R9: With control bit 7 at 1 (one-shot), expiry clears the run bit and the count stays at 0.
- R10: Writing 1 to status bit 0 clears the pending flag, and writing 0 leaves it set. An expiry in the same cycle as a clear leaves the flag set.
- R11: `irq_o` is high exactly when the pending flag and global enable bit 0 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_tick_i | input | 4 | One-cycle tick pulses, one per selectable source |
| addr_i | input | 8 | Register byte offset |
| wr_en_i | input | 1 | Write strobe |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Level interrupt |

## Verification
The assertions assume that the tick inputs are synchronous one-cycle enables. They also assume that each bus access lasts a single cycle, so a write is seen once. The bench drives every input on the falling edge and holds each write strobe and tick pulse for exactly one cycle. A reload and a tick can land in the same cycle, so the counter properties exclude that case and treat the reload as the winner. The bench also forces one deliberate collision, an expiry arriving together with a status clear, to show that the expiry takes precedence.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam logic [7:0] OFF_GLOB = 8'h00;
    localparam logic [7:0] OFF_STS  = 8'h04;
    localparam logic [7:0] OFF_CTL  = 8'h10;
    localparam logic [7:0] OFF_IVL  = 8'h14;
    localparam logic [7:0] OFF_CNT  = 8'h18;

    localparam int CTL_RUN     = 0;
    localparam int CTL_RLD     = 1;
    localparam int CTL_SRC_LO  = 2;
    localparam int CTL_PRE_LO  = 4;
    localparam int CTL_ONESHOT = 7;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_GLOB,
        SEL_STS,
        SEL_CTL,
        SEL_IVL,
        SEL_CNT
    } reg_sel_e;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int SRC_W = 2,
    parameter int PRE_W = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en_i,
    input  logic [(1<<SRC_W)-1:0]   src_tick_i,
    input  logic [SRC_W-1:0]        src_sel_i,
    input  logic [PRE_W-1:0]        div_sel_i,
    output logic                    tick_o
);
    localparam int PCNT_W = (1 << PRE_W) - 1;

    logic [PCNT_W-1:0] pre_d, pre_q;
    logic [PCNT_W-1:0] limit;
    logic              sel_tick;

    always_comb begin
        sel_tick = src_tick_i[src_sel_i];
        limit    = (PCNT_W'(1) << div_sel_i) - PCNT_W'(1);
        tick_o   = en_i && sel_tick && (pre_q == limit);
        pre_d    = pre_q;
        if (!en_i) begin
            pre_d = '0;
        end else if (sel_tick) begin
            pre_d = tick_o ? '0 : pre_q + PCNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R5: a stopped channel leaves the divider at zero
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> pre_q == '0);
    // R5: the divider wraps on every prescaled tick
    a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> pre_q == '0);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             oneshot_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             expire_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        expire_o = tick_i && !load_i && (cnt_q == CNT_W'(1));
        cnt_d    = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (tick_i) begin
            if (cnt_q != '0)     cnt_d = cnt_q - CNT_W'(1);
            else if (!oneshot_i) cnt_d = load_val_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !load_i && cnt_q != '0 |=> cnt_q == $past(cnt_q) - CNT_W'(1));
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i && !load_i |=> $stable(cnt_q));
    a_r3_copy: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> cnt_q == $past(load_val_i));
    a_r8_refill: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i && !load_i && !oneshot_i && cnt_q == '0 |=> cnt_q == $past(load_val_i));

endmodule

// File: rtl/mm_timer.sv
module mm_timer #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int SRC_W  = 2,
    parameter int PRE_W  = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [(1<<SRC_W)-1:0]  src_tick_i,
    input  logic [ADDR_W-1:0]      addr_i,
    input  logic                   wr_en_i,
    input  logic [DATA_W-1:0]      wdata_i,
    output logic [DATA_W-1:0]      rdata_o,
    output logic                   irq_o
);
    import tmr_pkg::*;

    typedef struct packed {
        logic             ie;
        logic             pend;
        logic             run;
        logic             oneshot;
        logic [SRC_W-1:0] src;
        logic [PRE_W-1:0] pre;
        logic [CNT_W-1:0] ivl;
    } regs_t;

    regs_t    r_d, r_q;
    reg_sel_e sel;
    logic     ctl_wr, sts_clr, load, tick, expire;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        if      (addr_i == ADDR_W'(OFF_GLOB)) sel = SEL_GLOB;
        else if (addr_i == ADDR_W'(OFF_STS))  sel = SEL_STS;
        else if (addr_i == ADDR_W'(OFF_CTL))  sel = SEL_CTL;
        else if (addr_i == ADDR_W'(OFF_IVL))  sel = SEL_IVL;
        else if (addr_i == ADDR_W'(OFF_CNT))  sel = SEL_CNT;
        else                                  sel = SEL_NONE;
    end

    always_comb begin
        ctl_wr  = wr_en_i && (sel == SEL_CTL);
        sts_clr = wr_en_i && (sel == SEL_STS) && wdata_i[0];
        load    = ctl_wr && wdata_i[CTL_RLD];
    end

    tmr_prescaler #(.SRC_W(SRC_W), .PRE_W(PRE_W)) u_pre (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (r_q.run),
        .src_tick_i (src_tick_i),
        .src_sel_i  (r_q.src),
        .div_sel_i  (r_q.pre),
        .tick_o     (tick)
    );

    tmr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .load_i     (load),
        .load_val_i (r_q.ivl),
        .oneshot_i  (r_q.oneshot),
        .cnt_o      (cnt),
        .expire_o   (expire)
    );

    always_comb begin
        r_d = r_q;
        if (wr_en_i && sel == SEL_GLOB) r_d.ie  = wdata_i[0];
        if (wr_en_i && sel == SEL_IVL)  r_d.ivl = wdata_i[CNT_W-1:0];
        if (sts_clr) r_d.pend = 1'b0;
        if (expire)  r_d.pend = 1'b1;
        if (ctl_wr) begin
            r_d.run     = wdata_i[CTL_RUN];
            r_d.oneshot = wdata_i[CTL_ONESHOT];
            r_d.src     = wdata_i[CTL_SRC_LO +: SRC_W];
            r_d.pre     = wdata_i[CTL_PRE_LO +: PRE_W];
        end else if (expire && r_q.oneshot) begin
            r_d.run = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        unique case (sel)
            SEL_GLOB: rdata_o[0] = r_q.ie;
            SEL_STS:  rdata_o[0] = r_q.pend;
            SEL_CTL: begin
                rdata_o[CTL_RUN]              = r_q.run;
                rdata_o[CTL_SRC_LO +: SRC_W]  = r_q.src;
                rdata_o[CTL_PRE_LO +: PRE_W]  = r_q.pre;
                rdata_o[CTL_ONESHOT]          = r_q.oneshot;
            end
            SEL_IVL:  rdata_o[CNT_W-1:0] = r_q.ivl;
            SEL_CNT:  rdata_o[CNT_W-1:0] = cnt;
            default:  rdata_o = '0;
        endcase
        irq_o = r_q.pend && r_q.ie;
    end

    a_r7_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> r_q.pend);
    a_r10_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        sts_clr && !expire |=> !r_q.pend);
    a_r9_oneshot_stop: assert property (@(posedge clk) disable iff (!rst_n)
        expire && r_q.oneshot && !ctl_wr |=> !r_q.run);
    a_r11_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
        !r_q.ie |-> !irq_o);

endmodule

// File: tb/tb_mm_timer.sv
module tb_mm_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  src_tick_i = '0;
    logic [7:0]  addr_i = '0;
    logic        wr_en_i = 1'b0;
    logic [31:0] wdata_i = '0;
    logic [31:0] rdata_o;
    logic        irq_o;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mm_timer dut (
        .clk(clk), .rst_n(rst_n), .src_tick_i(src_tick_i),
        .addr_i(addr_i), .wr_en_i(wr_en_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] tk = 4'b0);
        @(negedge clk);
        addr_i = a; wdata_i = d; wr_en_i = 1'b1; src_tick_i = tk;
        @(negedge clk);
        wr_en_i = 1'b0; src_tick_i = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic pulse(input logic [3:0] tk, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            src_tick_i = tk;
            @(negedge clk);
            src_tick_i = '0;
        end
    endtask

    task automatic chk_reg(input string tag, input logic [7:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(tag, v, exp);
    endtask

    task automatic t_reset;
        chk_reg("R1 glob", 8'h00, 0);
        chk_reg("R1 sts", 8'h04, 0);
        chk_reg("R1 ctl", 8'h10, 0);
        chk_reg("R1 ivl", 8'h14, 0);
        chk_reg("R1 cnt", 8'h18, 0);
        check("R1 irq", {31'b0, irq_o}, 0);
    endtask

    task automatic t_map;
        wr(8'h14, 32'h1234_5678);
        chk_reg("R2 ivl readback", 8'h14, 32'h1234_5678);
        wr(8'h10, 32'h0000_00F7);
        chk_reg("R2 ctl fields", 8'h10, 32'h0000_00F5);
        wr(8'h10, 32'h0);
        wr(8'h00, 32'h1);
        chk_reg("R2 glob", 8'h00, 1);
        wr(8'h00, 32'h0);
        chk_reg("R3 cnt after reload", 8'h18, 32'h1234_5678);
        wr(8'h18, 32'h0000_0042);
        chk_reg("R2 cnt write ignored", 8'h18, 32'h1234_5678);
        wr(8'h08, 32'hFFFF_FFFF);
        chk_reg("R2 unmapped read", 8'h08, 0);
        chk_reg("R2 unmapped write ignored", 8'h14, 32'h1234_5678);
    endtask

    task automatic t_reload_run_src;
        wr(8'h14, 32'd5);
        wr(8'h10, 32'h06);
        chk_reg("R3 copy while stopped", 8'h18, 5);
        chk_reg("R3 bit reads 0", 8'h10, 32'h04);
        pulse(4'b0010, 2);
        chk_reg("R4 hold while stopped", 8'h18, 5);
        wr(8'h10, 32'h05);
        pulse(4'b0010, 2);
        chk_reg("R4 decrement", 8'h18, 3);
        pulse(4'b1101, 3);
        chk_reg("R6 other sources ignored", 8'h18, 3);
        wr(8'h10, 32'h0D);
        pulse(4'b1000, 1);
        chk_reg("R6 source 3", 8'h18, 2);
        wr(8'h10, 32'h04);
        pulse(4'b0010, 3);
        chk_reg("R4 hold after stop", 8'h18, 2);
    endtask

    task automatic t_prescale;
        wr(8'h14, 32'd100);
        wr(8'h10, 32'h26);
        wr(8'h10, 32'h25);
        pulse(4'b0010, 3);
        chk_reg("R5 no tick before 4", 8'h18, 100);
        pulse(4'b0010, 1);
        chk_reg("R5 tick at 4", 8'h18, 99);
        pulse(4'b0010, 8);
        chk_reg("R5 two more", 8'h18, 97);
        pulse(4'b0010, 2);
        wr(8'h10, 32'h24);
        wr(8'h10, 32'h25);
        pulse(4'b0010, 3);
        chk_reg("R5 restart partial", 8'h18, 97);
        pulse(4'b0010, 1);
        chk_reg("R5 restart full", 8'h18, 96);
        wr(8'h10, 32'h74);
        wr(8'h10, 32'h75);
        pulse(4'b0010, 127);
        chk_reg("R5 div128 partial", 8'h18, 96);
        pulse(4'b0010, 1);
        chk_reg("R5 div128 tick", 8'h18, 95);
        wr(8'h10, 32'h04);
    endtask

    task automatic t_periodic;
        wr(8'h14, 32'd2);
        wr(8'h10, 32'h06);
        wr(8'h10, 32'h05);
        pulse(4'b0010, 1);
        chk_reg("R7 no pend at 1", 8'h04, 0);
        pulse(4'b0010, 1);
        chk_reg("R7 cnt zero", 8'h18, 0);
        chk_reg("R7 pend set", 8'h04, 1);
        check("R11 irq masked", {31'b0, irq_o}, 0);
        wr(8'h00, 32'h1);
        check("R11 irq on", {31'b0, irq_o}, 1);
        pulse(4'b0010, 1);
        chk_reg("R8 refill", 8'h18, 2);
        pulse(4'b0010, 2);
        chk_reg("R8 second expiry", 8'h18, 0);
        wr(8'h04, 32'h0);
        chk_reg("R10 write 0 keeps", 8'h04, 1);
        wr(8'h04, 32'h1);
        chk_reg("R10 write 1 clears", 8'h04, 0);
        check("R11 irq off", {31'b0, irq_o}, 0);
        wr(8'h10, 32'h04);
    endtask

    task automatic t_oneshot;
        wr(8'h14, 32'd3);
        wr(8'h10, 32'h86);
        wr(8'h10, 32'h85);
        pulse(4'b0010, 3);
        chk_reg("R9 cnt zero", 8'h18, 0);
        chk_reg("R9 run cleared", 8'h10, 32'h84);
        check("R11 irq oneshot", {31'b0, irq_o}, 1);
        pulse(4'b0010, 2);
        chk_reg("R9 stays zero", 8'h18, 0);
        wr(8'h04, 32'h1);
    endtask

    task automatic t_collide;
        wr(8'h14, 32'd1);
        wr(8'h10, 32'h06);
        wr(8'h10, 32'h05);
        wr(8'h04, 32'h1, 4'b0010);
        chk_reg("R10 expiry beats clear", 8'h04, 1);
        chk_reg("R10 collide cnt", 8'h18, 0);
        wr(8'h10, 32'h04);
        wr(8'h04, 32'h1);
        chk_reg("R10 final clear", 8'h04, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_map();
        t_reload_run_src();
        t_prescale();
        t_periodic();
        t_oneshot();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule